// File: doc/BRIEF.md
# DMA Trigger Event Prioritizer

This block sits in front of the event queues of a DMA controller. Each of the ordinary DMA channels can be started in three ways: a hardware request line, a chain trigger raised when another transfer completes, or a manual set by software. Each of the quick-DMA channels has a single trigger. Every trigger is a single-cycle pulse. The pulse is captured in its own pending flag, so a channel can hold up to three separate requests at once.

In each cycle the block offers at most one pending event to the queue side through a valid/ready handshake. The choice has two levels. Ordinary DMA channels always win over quick-DMA channels. Within each group, the lowest channel number wins. Inside one ordinary channel, the hardware request is served first, then the chain trigger, then the manual trigger. Each of these gives its own submission. The ordering applies only among events that are pending together. An event that has already been accepted is never withdrawn or re-offered.

The output is combinational from the pending flags. When the queue side takes the event, only the flag of the event it took is cleared. Parameter storage, the queues themselves and transfer execution belong to other blocks.

Top module: `dma_evt_prio`

## Requirements
- R1: After reset no flag is pending and `sub_valid_o` is low.
- R2: A trigger pulse on any input sets its pending flag at that clock edge. From the next cycle `sub_valid_o` is high and stays high while any flag is pending.
- R3: Among pending ordinary DMA events, the lowest channel number is offered first, whatever the trigger sources are.
- R4: While any ordinary DMA flag is pending, no quick-DMA event is offered.
- R5: A quick-DMA event is offered with `sub_is_qdma_o`=1, `sub_src_o`=3 and `sub_chan_o` equal to its channel index, lowest index first.
- R6: For an ordinary channel, `sub_is_qdma_o`=0 and `sub_src_o` gives the source: 0 is the hardware request, 1 is the chain trigger, 2 is the manual trigger. When several sources of one channel are pending, they are offered one per submission in the order 0, 1, 2.
- R7: While `sub_ready_i` is low and no new trigger arrives, the offered event and all pending flags stay unchanged.
- R8: A cycle with `sub_valid_o` and `sub_ready_i` both high clears exactly the flag of the offered event and no other.
- R9: A trigger on a flag in the same cycle that the flag is accepted leaves the flag pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| hw_evt_i | input | 64 | Hardware request pulses, one per DMA channel |
| chain_evt_i | input | 64 | Chain trigger pulses, one per DMA channel |
| man_evt_i | input | 64 | Manual trigger pulses, one per DMA channel |
| qdma_evt_i | input | 8 | Quick-DMA trigger pulses |
| sub_ready_i | input | 1 | Queue side accepts the offered event |
| sub_valid_o | output | 1 | An event is offered |
| sub_chan_o | output | 6 | Channel index of the offered event |
| sub_is_qdma_o | output | 1 | Offered event belongs to a quick-DMA channel |
| sub_src_o | output | 2 | Trigger source code of the offered event |

## Verification
Single triggers are swept over every channel and every source. This catches index encoding errors and source encoding errors, and it confirms that each acceptance empties the block. Adjacent-channel pairs join a manual trigger on the lower channel with a hardware request on the higher one. They tell channel-first ordering apart from source-first ordering. All three sources on one channel check the hardware, chain, manual sequence. The highest DMA channel paired with each quick-DMA channel checks that the group order wins over the channel number. Further stimuli hold `sub_ready_i` low with a trigger pending, and fire a trigger on the same flag in the cycle it is accepted. These two cases separate correct flag updates from a lost event or a premature clear.

// File: rtl/dma_evt_pkg.sv
package dma_evt_pkg;
    typedef enum logic [1:0] {
        SRC_HW     = 2'd0,
        SRC_CHAIN  = 2'd1,
        SRC_MANUAL = 2'd2,
        SRC_QDMA   = 2'd3
    } trig_src_e;
endpackage

// File: rtl/evt_first_set.sv
// Finds the lowest-numbered set bit of a request vector.
module evt_first_set #(
    parameter int W  = 64,
    localparam int IW = (W > 1) ? $clog2(W) : 1
) (
    input  logic [W-1:0]  req_i,
    output logic          found_o,
    output logic [IW-1:0] idx_o
);
    always_comb begin
        found_o = |req_i;
        idx_o   = '0;
        for (int i = W - 1; i >= 0; i--) begin
            if (req_i[i]) idx_o = IW'(i);
        end
    end
endmodule

// File: rtl/evt_src_pick.sv
// Picks the trigger source of one DMA channel: hardware, then chain, then manual.
module evt_src_pick
    import dma_evt_pkg::*;
(
    input  logic      hw_i,
    input  logic      chain_i,
    input  logic      man_i,
    output trig_src_e src_o
);
    always_comb begin
        if (hw_i)         src_o = SRC_HW;
        else if (chain_i) src_o = SRC_CHAIN;
        else if (man_i)   src_o = SRC_MANUAL;
        else              src_o = SRC_HW;
    end
endmodule

// File: rtl/dma_evt_prio.sv
module dma_evt_prio
    import dma_evt_pkg::*;
#(
    parameter int NUM_DMA  = 64,
    parameter int NUM_QDMA = 8,
    localparam int DI_W = $clog2(NUM_DMA),
    localparam int QI_W = $clog2(NUM_QDMA),
    localparam int CH_W = (DI_W > QI_W) ? DI_W : QI_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_DMA-1:0]  hw_evt_i,
    input  logic [NUM_DMA-1:0]  chain_evt_i,
    input  logic [NUM_DMA-1:0]  man_evt_i,
    input  logic [NUM_QDMA-1:0] qdma_evt_i,
    input  logic                sub_ready_i,
    output logic                sub_valid_o,
    output logic [CH_W-1:0]     sub_chan_o,
    output logic                sub_is_qdma_o,
    output logic [1:0]          sub_src_o
);
    typedef struct packed {
        logic [NUM_DMA-1:0]  hw;
        logic [NUM_DMA-1:0]  chain;
        logic [NUM_DMA-1:0]  man;
        logic [NUM_QDMA-1:0] qd;
    } pend_t;

    pend_t pend_d, pend_q;

    logic [NUM_DMA-1:0] dma_any;
    logic               dma_found, qd_found;
    logic [DI_W-1:0]    dma_idx;
    logic [QI_W-1:0]    qd_idx;
    trig_src_e          dma_src;
    logic               accept;

    assign dma_any = pend_q.hw | pend_q.chain | pend_q.man;

    evt_first_set #(.W(NUM_DMA)) i_dma_pick (
        .req_i   (dma_any),
        .found_o (dma_found),
        .idx_o   (dma_idx)
    );

    evt_first_set #(.W(NUM_QDMA)) i_qdma_pick (
        .req_i   (pend_q.qd),
        .found_o (qd_found),
        .idx_o   (qd_idx)
    );

    evt_src_pick i_src_pick (
        .hw_i    (pend_q.hw[dma_idx]),
        .chain_i (pend_q.chain[dma_idx]),
        .man_i   (pend_q.man[dma_idx]),
        .src_o   (dma_src)
    );

    always_comb begin
        sub_valid_o   = dma_found | qd_found;
        sub_is_qdma_o = !dma_found && qd_found;
        if (dma_found) begin
            sub_chan_o = CH_W'(dma_idx);
            sub_src_o  = dma_src;
        end else begin
            sub_chan_o = CH_W'(qd_idx);
            sub_src_o  = SRC_QDMA;
        end
        accept = sub_valid_o && sub_ready_i;

        pend_d = pend_q;
        if (accept) begin
            if (dma_found) begin
                case (dma_src)
                    SRC_HW:    pend_d.hw[dma_idx]    = 1'b0;
                    SRC_CHAIN: pend_d.chain[dma_idx] = 1'b0;
                    default:   pend_d.man[dma_idx]   = 1'b0;
                endcase
            end else begin
                pend_d.qd[qd_idx] = 1'b0;
            end
        end
        // new triggers are merged after the clear so a coincident pulse survives
        pend_d.hw    = pend_d.hw    | hw_evt_i;
        pend_d.chain = pend_d.chain | chain_evt_i;
        pend_d.man   = pend_d.man   | man_evt_i;
        pend_d.qd    = pend_d.qd    | qdma_evt_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pend_q <= '0;
        else        pend_q <= pend_d;
    end

    logic no_new_trig;
    assign no_new_trig = !(|hw_evt_i) && !(|chain_evt_i) && !(|man_evt_i) && !(|qdma_evt_i);

    AST_HOLD_UNTIL_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
        sub_valid_o && !sub_ready_i && no_new_trig |=> sub_valid_o && $stable(pend_q)); // R7
    AST_DMA_BEFORE_QDMA: assert property (@(posedge clk) disable iff (!rst_n)
        sub_valid_o && sub_is_qdma_o |-> (pend_q.hw == '0) && (pend_q.chain == '0) && (pend_q.man == '0)); // R4
    AST_QDMA_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        sub_valid_o && sub_is_qdma_o |-> sub_src_o == SRC_QDMA && pend_q.qd[sub_chan_o[QI_W-1:0]]); // R5
    AST_SRC_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
        sub_valid_o && !sub_is_qdma_o && sub_src_o != SRC_HW |-> !pend_q.hw[dma_idx]
        && (sub_src_o == SRC_CHAIN || !pend_q.chain[dma_idx])); // R6
    AST_CLEAR_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        sub_valid_o && sub_ready_i && no_new_trig |=> $countones(pend_q) == $past($countones(pend_q)) - 1); // R8
    AST_VALID_TRACKS_PEND: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_q != '0) == sub_valid_o); // R2
endmodule

// File: tb/test_dma_evt_prio.sv
module test_dma_evt_prio;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [63:0] hw_evt = '0, chain_evt = '0, man_evt = '0;
    logic [7:0]  qdma_evt = '0;
    logic        ready = 1'b0;
    logic        sub_valid;
    logic [5:0]  sub_chan;
    logic        sub_is_qdma;
    logic [1:0]  sub_src;
    int checks = 0;
    int fails  = 0;

    always #10 clk = ~clk;

    dma_evt_prio i_dma_evt_prio (
        .clk(clk), .rst_n(rst_n),
        .hw_evt_i(hw_evt), .chain_evt_i(chain_evt), .man_evt_i(man_evt),
        .qdma_evt_i(qdma_evt), .sub_ready_i(ready),
        .sub_valid_o(sub_valid), .sub_chan_o(sub_chan),
        .sub_is_qdma_o(sub_is_qdma), .sub_src_o(sub_src)
    );

    task automatic step();
        @(negedge clk);
        #1;
    endtask

    task automatic expect_out(input bit ev, input int ec, input bit eq, input int es, input string req);
        checks++;
        if (sub_valid !== ev || (ev && (sub_chan !== ec[5:0] || sub_is_qdma !== eq || sub_src !== es[1:0]))) begin
            fails++;
            $display("FAIL %s: got v=%0b ch=%0d q=%0b src=%0d, expected v=%0b ch=%0d q=%0b src=%0d",
                     req, sub_valid, sub_chan, sub_is_qdma, sub_src, ev, ec, eq, es);
        end
    endtask

    task automatic trig(input logic [63:0] h, input logic [63:0] c, input logic [63:0] m, input logic [7:0] q);
        hw_evt = h; chain_evt = c; man_evt = m; qdma_evt = q;
        step();
        hw_evt = '0; chain_evt = '0; man_evt = '0; qdma_evt = '0;
    endtask

    task automatic pop(input int ec, input bit eq, input int es, input string req);
        expect_out(1'b1, ec, eq, es, req);
        ready = 1'b1;
        step();
        ready = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: got timeout, expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        step(); step();
        expect_out(1'b0, 0, 1'b0, 0, "R1");
        rst_n = 1'b1;
        step();
        expect_out(1'b0, 0, 1'b0, 0, "R1");

        // R2/R6 single trigger on every DMA channel and source; R8 empties
        for (int c = 0; c < 64; c++) begin
            for (int s = 0; s < 3; s++) begin
                logic [63:0] bit_c;
                bit_c = 64'd1 << c;
                trig(s == 0 ? bit_c : '0, s == 1 ? bit_c : '0, s == 2 ? bit_c : '0, '0);
                pop(c, 1'b0, s, "R2");
                expect_out(1'b0, 0, 1'b0, 0, "R8");
            end
        end

        // R5 single quick-DMA triggers
        for (int q = 0; q < 8; q++) begin
            trig('0, '0, '0, 8'd1 << q);
            pop(q, 1'b1, 3, "R5");
            expect_out(1'b0, 0, 1'b0, 0, "R8");
        end

        // R3 lower channel manual beats higher channel hardware
        for (int i = 0; i < 63; i++) begin
            trig(64'd1 << (i + 1), '0, 64'd1 << i, '0);
            pop(i, 1'b0, 2, "R3");
            pop(i + 1, 1'b0, 0, "R3");
            expect_out(1'b0, 0, 1'b0, 0, "R8");
        end

        // R6 all three sources on one channel
        for (int k = 0; k < 3; k++) begin
            int c;
            c = (k == 0) ? 0 : (k == 1) ? 17 : 63;
            trig(64'd1 << c, 64'd1 << c, 64'd1 << c, '0);
            pop(c, 1'b0, 0, "R6");
            pop(c, 1'b0, 1, "R6");
            pop(c, 1'b0, 2, "R6");
            expect_out(1'b0, 0, 1'b0, 0, "R6");
        end

        // R4 highest DMA channel before any quick-DMA channel
        for (int q = 0; q < 8; q++) begin
            trig('0, '0, 64'd1 << 63, 8'd1 << q);
            pop(63, 1'b0, 2, "R4");
            pop(q, 1'b1, 3, "R4");
        end

        // R5 all quick-DMA channels at once, lowest first
        trig('0, '0, '0, 8'hFF);
        for (int q = 0; q < 8; q++) pop(q, 1'b1, 3, "R5");
        expect_out(1'b0, 0, 1'b0, 0, "R5");

        // R7 ready held low
        trig(64'd1 << 5, '0, 64'd1 << 40, 8'h02);
        for (int n = 0; n < 4; n++) begin
            expect_out(1'b1, 5, 1'b0, 0, "R7");
            step();
        end
        pop(5, 1'b0, 0, "R7");
        pop(40, 1'b0, 2, "R7");
        pop(1, 1'b1, 3, "R7");
        expect_out(1'b0, 0, 1'b0, 0, "R7");

        // R9 retrigger in the accept cycle survives
        trig('0, 64'd1 << 9, '0, '0);
        expect_out(1'b1, 9, 1'b0, 1, "R9");
        ready = 1'b1; chain_evt = 64'd1 << 9;
        step();
        ready = 1'b0; chain_evt = '0;
        pop(9, 1'b0, 1, "R9");
        expect_out(1'b0, 0, 1'b0, 0, "R9");

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule